// File: doc/BRIEF.md
# Serial Configuration Port with Shadowed Register Bank

This block is a three-wire serial slave for a configuration register space. A host frames each access with an active-low chip select, clocks a 16-bit command word in on a serial clock, and then moves one or more 8-bit data bytes on a single data line. For a read, the slave takes the data line over once the command is complete. The serial clock, chip select and data-in pins are oversampled by the system clock, so all state lives in one clock domain.

The registers that steer the rest of the chip form a contiguous shadowed window. A write to the window only updates the shadow copy. The active copy, which the chip sees on `cfg_q`, takes every shadow value in the same cycle when the host sets the commit bit. That bit clears itself. A small control register selects the data bit order and issues a soft reset. Two read-only registers report an identity byte and a grade byte.

Top module: `spi_cfg_regs`

## Requirements
- R1: A frame starts with `csb` low. The first 16 `sclk` rising edges carry the command word MSB-first: bit 15 is read (1) or write (0), bits 14:13 are the length code and bits 12:0 are the start address. `sclk` and `csb` are synchronous to `clk`, and each `sclk` level lasts at least two `clk` cycles.
- R2: Length codes 0, 1 and 2 transfer 1, 2 and 3 bytes, and any further bits in the frame are ignored. Code 3 streams bytes until `csb` rises. The address advances by one after each byte.
- R3: `sdio_oe` is high only inside a read frame, from the 16th command edge until the last byte in the length. Each data bit is presented after the preceding rising edge, and the host samples it on the next rising edge.
- R4: When bit 6 or bit 1 of register 0x00 is set, data bytes move LSB-first in both directions. The command word is always MSB-first.
- R5: A write to 0x08..0x18 changes only the shadow copy, and a read of these addresses returns the shadow copy. `cfg_q` (byte i = address 0x08+i) does not change on such a write.
- R6: Writing a byte with bit 0 set to address 0xFF copies every shadow register to `cfg_q` in the same cycle. Address 0xFF always reads 0x00.
- R7: Register 0x00 reads back bit 6 = bit 1 = LSB-first flag, bits 4 and 3 = 1, and all other bits 0. Its reset value is 0x18. A write with bit 5 or bit 2 set performs a soft reset: the LSB-first flag clears, and every shadow and active register that has a default returns to it.
- R8: Address 0x01 reads `CHIP_ID` and address 0x02 reads `GRADE`. Writes to these addresses have no effect.
- R9: `rst_n` low clears the LSB-first flag and loads the defaults into the shadow and active registers flagged in `DMASK`. Registers not flagged keep their contents.
- R10: Writes to addresses outside 0x00..0x02, 0x08..0x18 and 0xFF are ignored, and reads of those addresses return 0x00.
- R11: `csb` rising at any point ends the frame. A partial byte is discarded, `sdio_oe` goes low, and the next frame starts with a fresh command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; bits are captured on its rising edge |
| csb | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial read data to the host |
| sdio_oe | output | 1 | High while the slave drives the data line |
| cfg_q | output | NSH*8 | Active register copy; byte i belongs to address 0x08+i |

## Verification
Directed frames try each length code with one surplus byte appended. These frames show whether the byte limit and the output-enable window end at the right byte, and whether streaming crosses register boundaries. Writes to the shadow window are followed by checks of `cfg_q` before and after the commit byte, which separates shadow updates from active updates. Frames sent in both bit orders show whether the order flag is applied to data and not to the command word. Soft reset, the reset pin, and a frame cut short in mid-byte show which registers are restored and which keep their contents. A seeded random stream of reads and writes to valid, read-only and unmapped addresses is then compared against a bench model.

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int              SH_BASE = 8,
  parameter int              NSH     = 17,
  parameter logic [7:0]      CHIP_ID = 8'hA5,
  parameter logic [7:0]      GRADE   = 8'h20,
  parameter logic [NSH*8-1:0] DFLT   = '0,
  parameter logic [NSH-1:0]  DMASK   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             csb,
  input  logic             sdio_in,
  output logic             sdio_out,
  output logic             sdio_oe,
  output logic [NSH*8-1:0] cfg_q
);
  localparam int AW = 13;
  localparam logic [AW-1:0] XFER_ADDR = AW'(255);

  logic          sclk_q, rd, done, lsb;
  logic [4:0]    icnt;
  logic [14:0]   ish;
  logic [2:0]    bcnt;
  logic [1:0]    nb, len;
  logic [AW-1:0] addr;
  logic [7:0]    rxsh, txsh;
  logic [NSH*8-1:0] shadow_v;

  wire        rise     = sclk & ~sclk_q & ~csb;
  wire        in_data  = (icnt == 5'd16) && !done;
  wire [15:0] inst     = {ish, sdio_in};
  wire [7:0]  wbyte    = lsb ? {sdio_in, rxsh[7:1]} : {rxsh[6:0], sdio_in};
  wire        byte_end = rise && in_data && (bcnt == 3'd7);
  wire        we       = byte_end && !rd;
  wire        srst     = we && (addr == '0) && (wbyte[5] | wbyte[2]);
  wire        xfer     = we && (addr == XFER_ADDR) && wbyte[0];

  assign sdio_out = lsb ? txsh[0] : txsh[7];
  assign sdio_oe  = !csb && rd && in_data;

  function automatic logic [7:0] rdata(input logic [AW-1:0] a);
    logic [7:0] r;
    r = '0;
    if (a == AW'(0)) r = {1'b0, lsb, 3'b011, 1'b0, lsb, 1'b0};
    if (a == AW'(1)) r = CHIP_ID;
    if (a == AW'(2)) r = GRADE;
    for (int i = 0; i < NSH; i++)
      if (a == AW'(SH_BASE + i)) r = shadow_v[i*8 +: 8];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; icnt <= '0; ish <= '0; bcnt <= '0; nb <= '0; len <= '0;
      rd <= 1'b0; done <= 1'b0; addr <= '0; rxsh <= '0; txsh <= '0;
    end else begin
      sclk_q <= sclk;
      if (csb) begin
        icnt <= '0; bcnt <= '0; nb <= '0; done <= 1'b0;
      end else if (rise) begin
        if (icnt < 5'd16) begin
          ish  <= inst[14:0];
          icnt <= icnt + 5'd1;
          if (icnt == 5'd15) begin
            rd   <= inst[15];
            len  <= inst[14:13];
            addr <= inst[12:0];
            txsh <= rdata(inst[12:0]);
          end
        end else if (!done) begin
          bcnt <= bcnt + 3'd1;
          rxsh <= wbyte;
          txsh <= lsb ? {1'b0, txsh[7:1]} : {txsh[6:0], 1'b0};
          if (bcnt == 3'd7) begin
            addr <= addr + AW'(1);
            txsh <= rdata(addr + AW'(1));
            nb   <= nb + 2'd1;
            if (len != 2'd3 && nb == len) done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lsb <= 1'b0;
    else if (srst)             lsb <= 1'b0;
    else if (we && addr == '0) lsb <= wbyte[6] | wbyte[1];
  end

  for (genvar i = 0; i < NSH; i++) begin : g_reg
    logic [7:0] sh_r, act_r;
    wire hit = we && (addr == AW'(SH_BASE + i));
    if (DMASK[i]) begin : g_dflt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_r <= DFLT[i*8 +: 8]; act_r <= DFLT[i*8 +: 8];
        end else if (srst) begin
          sh_r <= DFLT[i*8 +: 8]; act_r <= DFLT[i*8 +: 8];
        end else begin
          if (hit)  sh_r  <= wbyte;
          if (xfer) act_r <= sh_r;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (hit)  sh_r  <= wbyte;
        if (xfer) act_r <= sh_r;
      end
    end
    assign shadow_v[i*8 +: 8] = sh_r;
    assign cfg_q[i*8 +: 8]    = act_r;
  end

  a_r3_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (!csb && rd));
  a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    csb |=> (!sdio_oe && bcnt == 3'd0));
  a_r2_len_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sdio_oe);
  a_r6_xfer_copy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cfg_q == $past(shadow_v)));
  a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !srst) |=> $stable(cfg_q));
endmodule

// File: tb/spi_cfg_regs_bench.sv
module spi_cfg_regs_bench;
  localparam int NSH = 17;
  localparam logic [7:0] ID = 8'hA5, GR = 8'h20;
  localparam logic [NSH-1:0] MASK = 17'h1FF0F;

  function automatic logic [NSH*8-1:0] mk_dflt();
    logic [NSH*8-1:0] v;
    for (int i = 0; i < NSH; i++) v[i*8 +: 8] = 8'(8'h30 + i * 7);
    return v;
  endfunction
  localparam logic [NSH*8-1:0] BDFLT = mk_dflt();

  logic clk = 0, rst_n = 0, sclk = 0, csb = 1, sdio_in = 0;
  logic sdio_out, sdio_oe;
  logic [NSH*8-1:0] cfg_q;
  int nchk = 0, nfail = 0;

  spi_cfg_regs #(.SH_BASE(8), .NSH(NSH), .CHIP_ID(ID), .GRADE(GR), .DFLT(BDFLT), .DMASK(MASK))
    u_spi_cfg_regs (.clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
                    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_q(cfg_q));

  always #4 clk = ~clk;

  logic [7:0] msh [NSH], mact [NSH];
  logic mlsb = 0;
  logic [7:0] wb [64], rb [64];
  logic oeall [64], oeany [64];

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input int a);
    if (a == 0) return {1'b0, mlsb, 3'b011, 1'b0, mlsb, 1'b0};
    if (a == 1) return ID;
    if (a == 2) return GR;
    if (a >= 8 && a < 8 + NSH) return msh[a-8];
    return 8'h00;
  endfunction

  task automatic m_write(input int a, input logic [7:0] d);
    if (a == 0) begin
      if (d[5] | d[2]) begin
        mlsb = 0;
        for (int i = 0; i < NSH; i++)
          if (MASK[i]) begin msh[i] = BDFLT[i*8 +: 8]; mact[i] = BDFLT[i*8 +: 8]; end
      end else mlsb = d[6] | d[1];
    end else if (a >= 8 && a < 8 + NSH) msh[a-8] = d;
    else if (a == 255 && d[0]) for (int i = 0; i < NSH; i++) mact[i] = msh[i];
  endtask

  function automatic logic [15:0] cmd(input bit r, input int l, input int a);
    return {r, 2'(l), 13'(a)};
  endfunction

  task automatic sbit(input logic b, output logic o, output logic e);
    sdio_in = b; sclk = 0; tick(2);
    o = sdio_out; e = sdio_oe;
    sclk = 1; tick(2);
  endtask

  task automatic frame(input logic [15:0] ins, input int nby, input int abort_at);
    logic o, e;
    int lim;
    lim = (ins[14:13] == 2'd3) ? 64 : int'(ins[14:13]) + 1;
    csb = 0; tick(1);
    for (int i = 0; i < 16; i++) sbit(ins[15-i], o, e);
    for (int k = 0; k < nby; k++) begin
      rb[k] = '0; oeall[k] = 1; oeany[k] = 0;
      for (int j = 0; j < 8; j++) begin
        int p;
        if (abort_at == k * 8 + j) begin
          csb = 1; tick(2);
          chk("R11 oe after abort", sdio_oe, 0);
          tick(2);
          return;
        end
        p = mlsb ? j : 7 - j;
        sbit(ins[15] ? 1'b0 : wb[k][p], o, e);
        rb[k][p] = o; oeall[k] &= e; oeany[k] |= e;
      end
      if (!ins[15] && k < lim) m_write(int'(ins[12:0]) + k, wb[k]);
    end
    csb = 1; tick(3);
  endtask

  task automatic rd_chk(input string tag, input int a, input int n);
    frame(cmd(1, 3, a), n, -1);
    for (int k = 0; k < n; k++) chk(tag, rb[k], mread(a + k));
  endtask

  task automatic cfg_chk(input string tag, input bit all);
    for (int i = 0; i < NSH; i++)
      if (all || MASK[i]) chk(tag, cfg_q[i*8 +: 8], mact[i]);
  endtask

  initial begin
    int seed, code, nby, a;
    bit r;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < NSH; i++) begin msh[i] = BDFLT[i*8 +: 8]; mact[i] = BDFLT[i*8 +: 8]; end
    tick(4); rst_n = 1; tick(2);

    cfg_chk("R9 reset defaults", 0);
    chk("R3 oe idle", sdio_oe, 0);
    rd_chk("R7 reg0 default", 0, 1);
    chk("R7 reg0 value", rb[0], 8'h18);
    rd_chk("R8 id/grade", 1, 2);

    for (int i = 0; i < NSH; i++) wb[i] = 8'($urandom);
    frame(cmd(0, 3, 8), NSH, -1);
    cfg_chk("R5 active unchanged", 0);
    rd_chk("R5 shadow readback", 8, NSH);
    wb[0] = 8'h01; frame(cmd(0, 0, 255), 1, -1);
    cfg_chk("R6 transfer", 1);
    rd_chk("R6 commit reads zero", 255, 1);

    wb[0] = 8'h11; wb[1] = 8'h22; frame(cmd(0, 0, 9), 2, -1);
    rd_chk("R2 one byte limit", 9, 2);
    frame(cmd(1, 1, 8), 3, -1);
    chk("R2 read byte0", rb[0], mread(8));
    chk("R2 read byte1", rb[1], mread(9));
    chk("R3 oe byte1", oeall[1], 1);
    chk("R3 oe off after length", oeany[2], 0);
    wb[0] = 8'h33; wb[1] = 8'h44; wb[2] = 8'h55; wb[3] = 8'h66;
    frame(cmd(0, 2, 16), 4, -1);
    rd_chk("R2 three byte limit", 16, 4);

    wb[0] = 8'hC3; frame(cmd(0, 0, 5), 1, -1);
    wb[0] = 8'h3C; frame(cmd(0, 0, 48), 1, -1);
    rd_chk("R10 undefined reads zero", 5, 1);
    rd_chk("R10 undefined reads zero", 48, 1);
    wb[0] = 8'h00; frame(cmd(0, 0, 1), 1, -1);
    rd_chk("R8 id write ignored", 1, 1);
    chk("R8 id value", rb[0], ID);

    wb[0] = 8'h42; frame(cmd(0, 0, 0), 1, -1);
    rd_chk("R4 reg0 lsb mode", 0, 1);
    chk("R7 reg0 lsb value", rb[0], 8'h5A);
    wb[0] = 8'h13; wb[1] = 8'h01; frame(cmd(0, 0, 12), 1, -1);
    rd_chk("R4 lsb-first data", 12, 1);
    frame(cmd(0, 0, 255), 1, -1);
    wb[0] = 8'h01; frame(cmd(0, 0, 255), 1, -1);
    cfg_chk("R4 lsb-first commit", 1);
    wb[0] = 8'h18; frame(cmd(0, 0, 0), 1, -1);
    rd_chk("R4 back to msb-first", 0, 1);

    wb[0] = 8'h7E; frame(cmd(0, 0, 11), 1, 3);
    rd_chk("R11 aborted write ignored", 11, 1);
    frame(cmd(1, 3, 8), 2, 4);
    rd_chk("R11 fresh frame after abort", 8, 2);

    for (int i = 0; i < NSH; i++) wb[i] = 8'(i * 13 + 1);
    frame(cmd(0, 3, 8), NSH, -1);
    wb[0] = 8'h01; frame(cmd(0, 0, 255), 1, -1);
    wb[0] = 8'h24; frame(cmd(0, 0, 0), 1, -1);
    cfg_chk("R7 soft reset active", 1);
    rd_chk("R7 soft reset shadow", 0, NSH + 8);

    wb[0] = 8'h02; frame(cmd(0, 0, 0), 1, -1);
    for (int i = 0; i < NSH; i++) wb[i] = 8'(8'hE0 - i * 5);
    frame(cmd(0, 3, 8), NSH, -1);
    wb[0] = 8'h01; frame(cmd(0, 0, 255), 1, -1);
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    mlsb = 0;
    for (int i = 0; i < NSH; i++)
      if (MASK[i]) begin msh[i] = BDFLT[i*8 +: 8]; mact[i] = BDFLT[i*8 +: 8]; end
    cfg_chk("R9 reset keeps others", 1);
    rd_chk("R9 reset readback", 0, NSH + 8);

    for (int it = 0; it < 300; it++) begin
      case ($urandom % 4)
        0: a = 1 + $urandom % 2;
        1: a = 255;
        default: a = 8 + $urandom % 24;
      endcase
      r = $urandom % 2;
      code = $urandom % 4;
      nby = (code == 3) ? 1 + $urandom % 5 : code + 1 + $urandom % 2;
      for (int k = 0; k < nby; k++) wb[k] = 8'($urandom);
      frame(cmd(r, code, a), nby, -1);
      if (r) begin
        for (int k = 0; k < nby; k++)
          if (code == 3 || k <= code) chk("R1 random read", rb[k], mread(a + k));
      end else cfg_chk("R1 random active", 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule